// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block is the power-management sequencer of a processor core. It follows the core through five states: running, halted, flushing caches while halted, stop-clock granted, and sleeping. Its inputs are a pulse that marks a completed HALT instruction, a stop-clock request, a sleep request, five wake events, a cache flush handshake and a configuration bit that permits full clock stopping. It drives clock-enable outputs for three clock domains and one-cycle requests for the special HALT and Stop Grant bus cycles. It also delivers the wake events to the core.

Wake events that arrive while the core must not take them are collected in a pending register and are not lost. When stop-clock is granted out of the halted state, the block records that fact in a flag. When the stop-clock request is later withdrawn, the flag sends the core back to the halted state and no second HALT bus cycle is issued. The core returns to running instead if a wake event arrived in the meantime. Pending events are handed to the core as a single pulse in the first cycle of the new state. A deep-sleep request is accepted at the port and has no effect.

Every output except the clock enables comes from a register and changes one clock edge after the inputs that cause it. The clock enables are decoded from the registered state and the configuration bit.

Top module: `lps_ctrl`

## Requirements
- R1: While `rst_n` is low, and at once when it falls (asynchronous), `state_o` is 0 (running), all bus-cycle and wake outputs are 0, the pending events and the came-from-halt flag are cleared, and all other inputs are ignored.
- R2: In running state (`state_o`=0), a `halt_done_i` pulse moves the block to halted (`state_o`=1) at the next edge. `halt_cyc_o` is high for exactly the first cycle of the halted state.
- R3: In halted state, any set bit of `wake_i` returns the block to running at the next edge. In running and halted state, `wake_o` repeats `wake_i` one cycle later. The bits of `wake_i` are bit0 SMI, bit1 INIT, bit2 BINIT, bit3 NMI and bit4 INTR.
- R4: In halted state, `flush_req_i` moves the block to flushing (`state_o`=2), where `flush_busy_o` is 1. `flush_done_i` then returns it to halted with no `halt_cyc_o` pulse, unless a wake event is pending (see R7).
- R5: `stopclk_req_i` in running or halted state moves the block to Stop Grant (`state_o`=3) at the next edge. `stpgnt_cyc_o` is high for exactly the first cycle of Stop Grant. The block records whether it came from the halted state.
- R6: In flushing, Stop Grant and sleep state, wake events are added to a pending register. `wake_o` stays 0 for as long as the block remains in those states.
- R7: When `stopclk_req_i` falls in Stop Grant, or `flush_done_i` arrives in flushing, the pending events together with the current `wake_i` appear on `wake_o` for one cycle, in the first cycle of the new state, and the pending register is cleared. The new state is running if any event was pending or if Stop Grant was entered from running; otherwise it is halted, with no `halt_cyc_o` pulse.
- R8: In Stop Grant, `sleep_req_i` moves the block to sleep (`state_o`=4). Sleep is left, back to Stop Grant, only when `sleep_req_i` falls. Neither move issues a bus-cycle pulse.
- R9: `deep_sleep_req_i` has no effect on any output in any state.
- R10: `core_clk_en_o` is 1 only in running and flushing state. `uncore_clk_en_o` is 0 only in Stop Grant or sleep with `clkstop_en_i`=1. `snoop_clk_en_o` is 0 only in sleep with `clkstop_en_i`=1.
- R11: In running state, `stopclk_req_i` takes priority over `halt_done_i`. In halted state, the order of priority is a wake event, then `flush_req_i`, then `stopclk_req_i`.
- R12: Each bus-cycle output is a one-cycle pulse, issued at most once per state entry and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_done_i | input | 1 | Pulse: HALT instruction completed |
| stopclk_req_i | input | 1 | Stop-clock request (level) |
| sleep_req_i | input | 1 | Sleep request (level) |
| deep_sleep_req_i | input | 1 | Deep-sleep request, ignored |
| flush_req_i | input | 1 | Cache flush request |
| flush_done_i | input | 1 | Cache flush finished |
| clkstop_en_i | input | 1 | Permit full clock stopping (default 0) |
| wake_i | input | WAKE_N | Wake events: SMI, INIT, BINIT, NMI, INTR |
| state_o | output | 3 | 0 run, 1 halt, 2 flush, 3 stop grant, 4 sleep |
| halt_cyc_o | output | 1 | Request a HALT special bus cycle |
| stpgnt_cyc_o | output | 1 | Request a Stop Grant special bus cycle |
| flush_busy_o | output | 1 | Flush in progress |
| wake_o | output | WAKE_N | Wake events delivered to the core |
| core_clk_en_o | output | 1 | Core clock enable |
| uncore_clk_en_o | output | 1 | Cache/uncore clock enable |
| snoop_clk_en_o | output | 1 | Bus snoop clock enable |

## Verification
State, bus-cycle pulses, flush indication and wake delivery are all due exactly one clock edge after the inputs that cause them. The clock enables follow the registered state in the same cycle, and they follow `clkstop_en_i` at once. The bench drives inputs on the falling edge and advances its reference model on the rising edge. It compares every output on the next falling edge, so each result is checked in the cycle it is due. An asynchronous reset is compared one time step after it is applied. A final check compares the total number of HALT pulses with the model's count.

// File: rtl/lps_pkg.sv
package lps_pkg;

    typedef enum logic [2:0] {
        ST_RUN    = 3'd0,
        ST_HALT   = 3'd1,
        ST_FLUSH  = 3'd2,
        ST_STPGNT = 3'd3,
        ST_SLEEP  = 3'd4
    } lps_state_e;

    typedef struct packed {
        lps_state_e st;
        logic       from_halt;
        logic       halt_cyc;
        logic       stpgnt_cyc;
    } lps_fsm_t;

    function automatic logic is_hold_state(input lps_state_e s);
        return (s == ST_FLUSH) || (s == ST_STPGNT) || (s == ST_SLEEP);
    endfunction

endpackage

// File: rtl/lps_fsm.sv
module lps_fsm
    import lps_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_done_i,
    input  logic       stopclk_req_i,
    input  logic       sleep_req_i,
    input  logic       flush_req_i,
    input  logic       flush_done_i,
    input  logic       wake_any_i,
    input  logic       pend_any_i,
    output lps_state_e st_o,
    output logic       halt_cyc_o,
    output logic       stpgnt_cyc_o,
    output logic       flush_busy_o,
    output logic       release_o
);

    lps_fsm_t q, d;
    logic     rel;

    always_comb begin
        d            = q;
        d.halt_cyc   = 1'b0;
        d.stpgnt_cyc = 1'b0;
        rel          = 1'b0;
        case (q.st)
            ST_RUN: begin
                if (stopclk_req_i) begin
                    d.st         = ST_STPGNT;
                    d.stpgnt_cyc = 1'b1;
                    d.from_halt  = 1'b0;
                end else if (halt_done_i) begin
                    d.st       = ST_HALT;
                    d.halt_cyc = 1'b1;
                end
            end
            ST_HALT: begin
                if (wake_any_i) begin
                    d.st = ST_RUN;
                end else if (flush_req_i) begin
                    d.st = ST_FLUSH;
                end else if (stopclk_req_i) begin
                    d.st         = ST_STPGNT;
                    d.stpgnt_cyc = 1'b1;
                    d.from_halt  = 1'b1;
                end
            end
            ST_FLUSH: begin
                if (flush_done_i) begin
                    rel  = 1'b1;
                    d.st = pend_any_i ? ST_RUN : ST_HALT;
                end
            end
            ST_STPGNT: begin
                if (!stopclk_req_i) begin
                    rel         = 1'b1;
                    d.st        = (pend_any_i || !q.from_halt) ? ST_RUN : ST_HALT;
                    d.from_halt = 1'b0;
                end else if (sleep_req_i) begin
                    d.st = ST_SLEEP;
                end
            end
            ST_SLEEP: begin
                if (!sleep_req_i) begin
                    d.st = ST_STPGNT;
                end
            end
            default: begin
                d.st = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_RUN, from_halt: 1'b0, halt_cyc: 1'b0, stpgnt_cyc: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign st_o         = q.st;
    assign halt_cyc_o   = q.halt_cyc;
    assign stpgnt_cyc_o = q.stpgnt_cyc;
    assign flush_busy_o = (q.st == ST_FLUSH);
    assign release_o    = rel;

endmodule

// File: rtl/lps_wake.sv
module lps_wake
    import lps_pkg::*;
#(
    parameter int unsigned WAKE_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lps_state_e        st_i,
    input  logic              release_i,
    input  logic [WAKE_N-1:0] wake_i,
    output logic [WAKE_N-1:0] wake_o,
    output logic              wake_any_o,
    output logic              pend_any_o
);

    typedef struct packed {
        logic [WAKE_N-1:0] pend;
        logic [WAKE_N-1:0] wake;
    } wake_reg_t;

    wake_reg_t         q, d;
    logic [WAKE_N-1:0] merged;

    assign merged = q.pend | wake_i;

    always_comb begin
        d      = q;
        d.wake = '0;
        if (release_i) begin
            d.wake = merged;
            d.pend = '0;
        end else if (is_hold_state(st_i)) begin
            d.pend = merged;
        end else begin
            d.wake = wake_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign wake_o     = q.wake;
    assign wake_any_o = |wake_i;
    assign pend_any_o = |merged;

endmodule

// File: rtl/lps_gate.sv
module lps_gate
    import lps_pkg::*;
(
    input  lps_state_e st_i,
    input  logic       clkstop_en_i,
    output logic       core_clk_en_o,
    output logic       uncore_clk_en_o,
    output logic       snoop_clk_en_o
);

    logic granted;

    always_comb begin
        granted         = (st_i == ST_STPGNT) || (st_i == ST_SLEEP);
        core_clk_en_o   = (st_i == ST_RUN) || (st_i == ST_FLUSH);
        uncore_clk_en_o = !(granted && clkstop_en_i);
        snoop_clk_en_o  = !((st_i == ST_SLEEP) && clkstop_en_i);
    end

endmodule

// File: rtl/lps_ctrl.sv
module lps_ctrl
    import lps_pkg::*;
#(
    parameter int unsigned WAKE_N = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_done_i,
    input  logic              stopclk_req_i,
    input  logic              sleep_req_i,
    input  logic              deep_sleep_req_i,
    input  logic              flush_req_i,
    input  logic              flush_done_i,
    input  logic              clkstop_en_i,
    input  logic [WAKE_N-1:0] wake_i,
    output logic [2:0]        state_o,
    output logic              halt_cyc_o,
    output logic              stpgnt_cyc_o,
    output logic              flush_busy_o,
    output logic [WAKE_N-1:0] wake_o,
    output logic              core_clk_en_o,
    output logic              uncore_clk_en_o,
    output logic              snoop_clk_en_o
);

    lps_state_e st;
    logic       rel;
    logic       wake_any;
    logic       pend_any;
    logic       unused_deep_sleep;

    // Deep sleep does not exist in this controller; the request is dropped.
    assign unused_deep_sleep = deep_sleep_req_i;

    lps_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .halt_done_i  (halt_done_i),
        .stopclk_req_i(stopclk_req_i),
        .sleep_req_i  (sleep_req_i),
        .flush_req_i  (flush_req_i),
        .flush_done_i (flush_done_i),
        .wake_any_i   (wake_any),
        .pend_any_i   (pend_any),
        .st_o         (st),
        .halt_cyc_o   (halt_cyc_o),
        .stpgnt_cyc_o (stpgnt_cyc_o),
        .flush_busy_o (flush_busy_o),
        .release_o    (rel)
    );

    lps_wake #(.WAKE_N(WAKE_N)) u_wake (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_i      (st),
        .release_i (rel),
        .wake_i    (wake_i),
        .wake_o    (wake_o),
        .wake_any_o(wake_any),
        .pend_any_o(pend_any)
    );

    lps_gate u_gate (
        .st_i           (st),
        .clkstop_en_i   (clkstop_en_i),
        .core_clk_en_o  (core_clk_en_o),
        .uncore_clk_en_o(uncore_clk_en_o),
        .snoop_clk_en_o (snoop_clk_en_o)
    );

    assign state_o = st;

endmodule

// File: rtl/lps_chk.sv
module lps_chk
    import lps_pkg::*;
#(
    parameter int unsigned WAKE_N = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        state_o,
    input logic              halt_cyc_o,
    input logic              stpgnt_cyc_o,
    input logic              flush_busy_o,
    input logic [WAKE_N-1:0] wake_o,
    input logic              clkstop_en_i,
    input logic              core_clk_en_o,
    input logic              uncore_clk_en_o,
    input logic              snoop_clk_en_o
);

    logic hold_now;
    assign hold_now = (state_o == 3'd2) || (state_o == 3'd3) || (state_o == 3'd4);

    a_r2_halt_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cyc_o |-> (state_o == 3'd1 && $past(state_o) == 3'd0));

    a_r5_sg_pulse_on_entry: assert property (@(posedge clk) disable iff (!rst_n)
        stpgnt_cyc_o |-> (state_o == 3'd3 && ($past(state_o) == 3'd0 || $past(state_o) == 3'd1)));

    a_r12_halt_not_twice: assert property (@(posedge clk) disable iff (!rst_n)
        halt_cyc_o |=> !halt_cyc_o);

    a_r12_sg_not_twice: assert property (@(posedge clk) disable iff (!rst_n)
        stpgnt_cyc_o |=> !stpgnt_cyc_o);

    a_r6_wake_held: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_now && $past(hold_now)) |-> (wake_o == '0));

    a_r7_quiet_return: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd1 && $past(state_o) != 3'd0) |-> !halt_cyc_o);

    a_r8_sleep_from_sg: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && $past(state_o) != 3'd4) |-> ($past(state_o) == 3'd3 && !stpgnt_cyc_o));

    a_r4_flush_from_halt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flush_busy_o) |-> $past(state_o) == 3'd1);

    a_r10_full_stop_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && clkstop_en_i) |-> (!core_clk_en_o && !uncore_clk_en_o && !snoop_clk_en_o));

endmodule

bind lps_ctrl lps_chk #(.WAKE_N(WAKE_N)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .state_o        (state_o),
    .halt_cyc_o     (halt_cyc_o),
    .stpgnt_cyc_o   (stpgnt_cyc_o),
    .flush_busy_o   (flush_busy_o),
    .wake_o         (wake_o),
    .clkstop_en_i   (clkstop_en_i),
    .core_clk_en_o  (core_clk_en_o),
    .uncore_clk_en_o(uncore_clk_en_o),
    .snoop_clk_en_o (snoop_clk_en_o)
);

// File: tb/sim_lps_ctrl.sv
module sim_lps_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int W          = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         halt_done = 1'b0, stopclk = 1'b0, sleep = 1'b0, deep = 1'b0;
    logic         flush_req = 1'b0, flush_done = 1'b0, clkstop_en = 1'b0;
    logic [W-1:0] wake = '0;
    logic [2:0]   state_o;
    logic         halt_cyc_o, stpgnt_cyc_o, flush_busy_o;
    logic [W-1:0] wake_o;
    logic         core_en, uncore_en, snoop_en;

    int n_chk = 0;
    int n_bad = 0;
    int dut_halt_pulses = 0;

    // reference model state
    int           m_st = 0;
    bit           m_from = 0;
    bit [W-1:0]   m_pend = '0;
    bit [W-1:0]   m_wake = '0;
    bit           m_hc = 0, m_sg = 0;
    int           m_halt_pulses = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lps_ctrl #(.WAKE_N(W)) u0 (
        .clk(clk), .rst_n(rst_n), .halt_done_i(halt_done), .stopclk_req_i(stopclk),
        .sleep_req_i(sleep), .deep_sleep_req_i(deep), .flush_req_i(flush_req),
        .flush_done_i(flush_done), .clkstop_en_i(clkstop_en), .wake_i(wake),
        .state_o(state_o), .halt_cyc_o(halt_cyc_o), .stpgnt_cyc_o(stpgnt_cyc_o),
        .flush_busy_o(flush_busy_o), .wake_o(wake_o), .core_clk_en_o(core_en),
        .uncore_clk_en_o(uncore_en), .snoop_clk_en_o(snoop_en)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_st = 0; m_from = 0; m_pend = '0; m_wake = '0; m_hc = 0; m_sg = 0;
    endtask

    // Behavioural reference, one call per rising edge.
    task automatic model_step();
        int         ns;
        bit         go_out;
        bit [W-1:0] all;
        if (!rst_n) begin
            model_reset();
            return;
        end
        ns = m_st; go_out = 0; all = m_pend | wake;
        m_hc = 0; m_sg = 0;
        if (m_st == 0) begin
            if (stopclk) begin ns = 3; m_sg = 1; m_from = 0; end
            else if (halt_done) begin ns = 1; m_hc = 1; m_halt_pulses++; end
        end else if (m_st == 1) begin
            if (wake != 0) ns = 0;
            else if (flush_req) ns = 2;
            else if (stopclk) begin ns = 3; m_sg = 1; m_from = 1; end
        end else if (m_st == 2) begin
            if (flush_done) begin go_out = 1; ns = (all != 0) ? 0 : 1; end
        end else if (m_st == 3) begin
            if (!stopclk) begin
                go_out = 1;
                ns = (all == 0 && m_from) ? 1 : 0;
                m_from = 0;
            end else if (sleep) ns = 4;
        end else begin
            if (!sleep) ns = 3;
        end
        if (go_out) begin m_wake = all; m_pend = '0; end
        else if (m_st >= 2) begin m_wake = '0; m_pend = all; end
        else m_wake = wake;
        m_st = ns;
    endtask

    task automatic compare(input string ctx);
        int ex_core, ex_unc, ex_snp;
        ex_core = (m_st == 0 || m_st == 2) ? 1 : 0;
        ex_unc  = ((m_st == 3 || m_st == 4) && clkstop_en) ? 0 : 1;
        ex_snp  = (m_st == 4 && clkstop_en) ? 0 : 1;
        if (halt_cyc_o) dut_halt_pulses++;
        chk({ctx, " R2/R4/R5/R7/R8 state"}, int'(state_o), m_st);
        chk({ctx, " R2/R12 halt_cyc"}, int'(halt_cyc_o), int'(m_hc));
        chk({ctx, " R5/R12 stpgnt_cyc"}, int'(stpgnt_cyc_o), int'(m_sg));
        chk({ctx, " R4 flush_busy"}, int'(flush_busy_o), (m_st == 2) ? 1 : 0);
        chk({ctx, " R3/R6/R7 wake_o"}, int'(wake_o), int'(m_wake));
        chk({ctx, " R10 core_clk_en"}, int'(core_en), ex_core);
        chk({ctx, " R10 uncore_clk_en"}, int'(uncore_en), ex_unc);
        chk({ctx, " R10 snoop_clk_en"}, int'(snoop_en), ex_snp);
    endtask

    task automatic tick(input string ctx);
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(ctx);
    endtask

    task automatic run(input int n, input string ctx);
        for (int i = 0; i < n; i++) tick(ctx);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++; n_chk++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        model_reset();
        compare("R1 reset");
        rst_n = 1'b1;
        run(2, "R1 idle");

        // R2: halt entry, R3: INTR wakes
        halt_done = 1; tick("R2 halt"); halt_done = 0; run(2, "R2 halted");
        wake = 5'b10000; tick("R3 intr"); wake = 0; run(2, "R3 running");

        // R11: stop-clock beats halt in running; release to running (R7)
        halt_done = 1; stopclk = 1; tick("R11 run prio"); halt_done = 0;
        run(2, "R5 sg"); stopclk = 0; run(2, "R7 back to run");

        // R4: flush in halt
        halt_done = 1; tick("R4 halt"); halt_done = 0; tick("R4 halted");
        flush_req = 1; tick("R4 flush"); flush_req = 0; run(3, "R4 flushing");
        flush_done = 1; tick("R4 done"); flush_done = 0; run(2, "R4 back halt");

        // R5/R6/R7: halt -> sg, NMI held, release to running with pulse
        stopclk = 1; tick("R5 sg from halt"); run(2, "R5 sg");
        wake = 5'b01000; tick("R6 nmi held"); wake = 0; run(3, "R6 held");
        stopclk = 0; run(3, "R7 release pending");

        // R7: halt -> sg -> halt with no HALT cycle, then SMI
        halt_done = 1; tick("R7 halt"); halt_done = 0;
        stopclk = 1; run(3, "R7 sg"); stopclk = 0; run(3, "R7 quiet return");
        wake = 5'b00001; tick("R3 smi"); wake = 0; run(2, "R3 run");

        // R8/R9/R10: sleep with full clock stop, INIT held, deep sleep ignored
        clkstop_en = 1; stopclk = 1; run(2, "R10 sg full stop");
        sleep = 1; run(2, "R8 sleep");
        deep = 1; wake = 5'b00010; tick("R9 deep in sleep"); wake = 0; run(2, "R6 sleep held");
        deep = 0; stopclk = 0; run(2, "R8 stays asleep");
        sleep = 0; run(3, "R8 wake up path");

        // R11: halt priorities
        halt_done = 1; tick("R11 halt"); halt_done = 0;
        wake = 5'b00100; flush_req = 1; tick("R11 wake over flush"); wake = 0; flush_req = 0; run(2, "R11 run");
        halt_done = 1; tick("R11 halt2"); halt_done = 0;
        flush_req = 1; stopclk = 1; tick("R11 flush over stop"); flush_req = 0; run(2, "R11 flushing");
        flush_done = 1; tick("R11 flush done"); flush_done = 0; run(2, "R5 sg after flush");
        stopclk = 0; run(2, "R7 back halt");

        // R7: wake during flush sends core to running
        flush_req = 1; tick("R4 flush2"); flush_req = 0;
        wake = 5'b00001; tick("R6 wake in flush"); wake = 0; run(1, "R6 flushing");
        flush_done = 1; tick("R7 flush release"); flush_done = 0; run(2, "R7 run");

        // R9: deep sleep in running
        deep = 1; run(3, "R9 deep in run"); deep = 0;

        // R1: reset in the middle of sleep
        stopclk = 1; sleep = 1; run(3, "R8 sleep2");
        wake = 5'b00100; tick("R6 held pre-reset"); wake = 0;
        rst_n = 0; model_reset(); #1; compare("R1 async reset");
        @(negedge clk); compare("R1 reset held");
        stopclk = 0; sleep = 0; rst_n = 1; run(2, "R1 after reset");

        // R10: partial gating when clock stop not permitted
        clkstop_en = 0; stopclk = 1; sleep = 1; run(3, "R10 partial");
        sleep = 0; stopclk = 0; run(3, "R10 exit");

        // R12: total HALT pulse count
        chk("R12 halt pulse count", dut_halt_pulses, m_halt_pulses);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule